// File: doc/BRIEF.md
# Dual Carry-Chain Adder

This block is an add-with-carry unit that keeps two separate one-bit carry chains inside a single flag register. The first operation kind takes its carry-in from the carry flag at bit 0 and writes its carry-out back to that bit only. The second kind does the same with the overflow flag at bit 11. Neither kind ever reads or writes the other chain's bit. Operations of the two kinds can therefore be issued in any interleaved order, one per clock, and each chain behaves as if the other did not exist. This suits multi-word arithmetic where two independent additions share one flag register.

Each operation can work on the full 64-bit width or on a 32-bit width. In 32-bit mode only the low halves of the operands take part, the carry-out comes from bit 32 of the sum, and the upper 32 result bits are zero. The whole flag register can also be loaded and read directly, so that the surrounding logic can set the starting carries.

Top module: `dual_chain_adder`

## Requirements
- R1: After reset the flag register and the result register both read zero.
- R2: With op_valid high and op_chain = 0 (carry chain), the result equals opa + opb + flags[0], and flags[0] takes the carry-out on the same clock edge.
- R3: With op_valid high and op_chain = 1 (overflow chain), the result equals opa + opb + flags[11], and flags[11] takes the carry-out on the same clock edge.
- R4: An operation leaves every flag bit other than the one its own chain writes unchanged.
- R5: In back-to-back operations of different kinds, in either order, each operation takes its carry-in only from its own chain's flag bit.
- R6: With op_wide = 0, operand bits 63:32 are ignored, result bits 63:32 are zero, and the carry-out is bit 32 of the 33-bit sum of the low halves and the carry-in.
- R7: When flag_ld is high, the flag register takes flag_ld_data at the clock edge; this overrides a flag update by an operation issued in the same cycle, whose result is still written.
- R8: When neither op_valid nor flag_ld is high, the result and flag registers keep their values.
- R9: With opb all ones in the selected width, the result is opa + carry_in − 1 in that width and the carry-out equals (carry_in OR opa nonzero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Perform an operation at this edge |
| op_chain | input | 1 | 0 = carry-flag chain, 1 = overflow-flag chain |
| op_wide | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| flag_ld | input | 1 | Load the whole flag register |
| flag_ld_data | input | 16 | Value to load into the flag register |
| sum_q | output | 64 | Registered result of the last operation |
| flags_q | output | 16 | Current flag register |

## Verification
The central sweep loads every one of the 16 combinations of starting carry flag, starting overflow flag and the two operands being zero or nonzero, then issues an all-ones addition on each chain back to back in both orders and in both widths; a design that draws one chain's carry from the other's bit fails exactly in the combinations where the two starting flags differ. A second sweep of pseudo-random operand pairs with random starting flags checks sums and carries against arithmetic done at full precision, with 32-bit cases carrying nonzero upper operand bits to show they are dropped. Directed cases cover a load together with an operation, idle cycles, and the preservation of all unrelated flag bits.

// File: rtl/dca_pkg.sv
package dca_pkg;

  typedef enum logic {
    CHAIN_C = 1'b0,
    CHAIN_O = 1'b1
  } chain_e;

endpackage

// File: rtl/dca_carry_sel.sv
module dca_carry_sel
  import dca_pkg::*;
#(
  parameter int FLAG_W = 16,
  parameter int C_BIT  = 0,
  parameter int O_BIT  = 11
) (
  input  logic [FLAG_W-1:0] flags,
  input  chain_e            chain,
  output logic              carry_in,
  output logic [FLAG_W-1:0] wr_mask
);

  always_comb begin
    wr_mask = '0;
    if (chain == CHAIN_O) begin
      carry_in       = flags[O_BIT];
      wr_mask[O_BIT] = 1'b1;
    end else begin
      carry_in       = flags[C_BIT];
      wr_mask[C_BIT] = 1'b1;
    end
  end

endmodule

// File: rtl/dca_add_core.sv
module dca_add_core #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              wide,
  output logic [DATA_W-1:0] sum,
  output logic              cout
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W:0] full_s;
  logic [HALF_W:0] half_s;

  always_comb begin
    full_s = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
    half_s = {1'b0, a[HALF_W-1:0]} + {1'b0, b[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
    if (wide) begin
      sum  = full_s[DATA_W-1:0];
      cout = full_s[DATA_W];
    end else begin
      sum  = {{(DATA_W-HALF_W){1'b0}}, half_s[HALF_W-1:0]};
      cout = half_s[HALF_W];
    end
  end

endmodule

// File: rtl/dca_flag_reg.sv
module dca_flag_reg #(
  parameter int FLAG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [FLAG_W-1:0] ld_data,
  input  logic              upd_en,
  input  logic [FLAG_W-1:0] upd_mask,
  input  logic              upd_bit,
  output logic [FLAG_W-1:0] flags_q
);

  logic [FLAG_W-1:0] flags_d;
  logic              flags_en;

  always_comb begin
    flags_en = ld | upd_en;
    if (ld) begin
      flags_d = ld_data;
    end else begin
      flags_d = (flags_q & ~upd_mask) | (upd_mask & {FLAG_W{upd_bit}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  AST_FLAGS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> flags_q == $past(ld_data)); // R7

  AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ld && !upd_en |=> $stable(flags_q)); // R8

  AST_FLAGS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    !ld && upd_en |=> (flags_q & ~$past(upd_mask)) == ($past(flags_q) & ~$past(upd_mask))); // R4

endmodule

// File: rtl/dual_chain_adder.sv
module dual_chain_adder
  import dca_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int FLAG_W = 16,
  parameter int C_BIT  = 0,
  parameter int O_BIT  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_chain,
  input  logic              op_wide,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              flag_ld,
  input  logic [FLAG_W-1:0] flag_ld_data,
  output logic [DATA_W-1:0] sum_q,
  output logic [FLAG_W-1:0] flags_q
);

  localparam int HALF_W = DATA_W / 2;

  chain_e            chain;
  logic              carry_in;
  logic [FLAG_W-1:0] wr_mask;
  logic [DATA_W-1:0] sum_d;
  logic              carry_out;

  assign chain = chain_e'(op_chain);

  dca_carry_sel #(
    .FLAG_W (FLAG_W),
    .C_BIT  (C_BIT),
    .O_BIT  (O_BIT)
  ) u_sel (
    .flags    (flags_q),
    .chain    (chain),
    .carry_in (carry_in),
    .wr_mask  (wr_mask)
  );

  dca_add_core #(
    .DATA_W (DATA_W)
  ) u_add (
    .a    (opa),
    .b    (opb),
    .cin  (carry_in),
    .wide (op_wide),
    .sum  (sum_d),
    .cout (carry_out)
  );

  dca_flag_reg #(
    .FLAG_W (FLAG_W)
  ) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       (flag_ld),
    .ld_data  (flag_ld_data),
    .upd_en   (op_valid),
    .upd_mask (wr_mask),
    .upd_bit  (carry_out),
    .flags_q  (flags_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (op_valid) begin
      sum_q <= sum_d;
    end
  end

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_wide |=> sum_q[DATA_W-1:HALF_W] == '0); // R6

  AST_C_KEEPS_O: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !flag_ld && !op_chain |=> flags_q[O_BIT] == $past(flags_q[O_BIT])); // R5

  AST_O_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !flag_ld && op_chain |=> flags_q[C_BIT] == $past(flags_q[C_BIT])); // R5

  AST_SUM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(sum_q)); // R8

endmodule

// File: tb/dual_chain_adder_test.sv
`timescale 1ns/1ps
module dual_chain_adder_test;

  localparam int DW = 64;
  localparam int FW = 16;
  localparam int CB = 0;
  localparam int OB = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic          op_chain = 1'b0;
  logic          op_wide = 1'b1;
  logic [DW-1:0] opa = '0;
  logic [DW-1:0] opb = '0;
  logic          flag_ld = 1'b0;
  logic [FW-1:0] flag_ld_data = '0;
  logic [DW-1:0] sum_q;
  logic [FW-1:0] flags_q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [FW-1:0] mflags;
  logic [63:0]   lfsr = 64'h1234_5678_9abc_def1;

  always #2.5 clk = ~clk;

  dual_chain_adder uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_chain(op_chain),
    .op_wide(op_wide), .opa(opa), .opb(opb), .flag_ld(flag_ld),
    .flag_ld_data(flag_ld_data), .sum_q(sum_q), .flags_q(flags_q)
  );

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] next_rand(input logic [63:0] s);
    return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
  endfunction

  // expected sum and carry from arithmetic at full precision
  task automatic model(input logic ch, input logic w, input logic [DW-1:0] a,
                       input logic [DW-1:0] b, output logic [DW-1:0] s,
                       output logic c);
    logic [DW:0] t;
    logic ci;
    ci = ch ? mflags[OB] : mflags[CB];
    if (w) begin
      t = {1'b0, a} + {1'b0, b} + 65'(ci);
      s = t[DW-1:0];
      c = t[DW];
    end else begin
      t = 65'(a[31:0]) + 65'(b[31:0]) + 65'(ci);
      s = {32'h0, t[31:0]};
      c = t[32];
    end
    if (ch) mflags[OB] = c; else mflags[CB] = c;
  endtask

  task automatic load(input logic [FW-1:0] v);
    @(negedge clk);
    flag_ld = 1'b1; flag_ld_data = v;
    @(negedge clk);
    flag_ld = 1'b0;
    mflags = v;
  endtask

  // issue one op; result sampled 1 ns after the edge that captures it
  task automatic issue(input logic ch, input logic w, input logic [DW-1:0] a,
                       input logic [DW-1:0] b, output logic [DW-1:0] s_got,
                       output logic [FW-1:0] f_got);
    @(negedge clk);
    op_valid = 1'b1; op_chain = ch; op_wide = w; opa = a; opb = b;
    @(posedge clk);
    #1;
    s_got = sum_q; f_got = flags_q;
    op_valid = 1'b0;
  endtask

  task automatic run_pair(input logic first_o, input logic w, input int combo);
    logic ic, io, xc, xo;
    logic [DW-1:0] ones, ac, ao, s1, s2, e1, e2, expc, expo;
    logic [FW-1:0] f1, f2, base;
    logic c1, c2;
    ic = combo[0]; io = combo[1]; xc = combo[2]; xo = combo[3];
    ones = w ? '1 : 64'h0000_0000_ffff_ffff;
    ac = xc ? (w ? 64'h8000_0000_0000_0001 : 64'hdead_0000_8000_0001) : (w ? 64'h0 : 64'hffff_0000_0000_0000);
    ao = xo ? 64'h1 : 64'h0;
    base = 16'h5a5a & ~16'h0801;
    base[CB] = ic; base[OB] = io;
    load(base);
    @(negedge clk);
    op_valid = 1'b1; op_chain = first_o; op_wide = w;
    opa = first_o ? ao : ac; opb = ones;
    model(first_o, w, opa, opb, e1, c1);
    @(posedge clk); #1;
    s1 = sum_q; f1 = flags_q;
    @(negedge clk);
    op_chain = ~first_o;
    opa = first_o ? ac : ao; opb = ones;
    model(~first_o, w, opa, opb, e2, c2);
    @(posedge clk); #1;
    s2 = sum_q; f2 = flags_q;
    op_valid = 1'b0;
    check($sformatf("R2/R3 first sum combo=%0d ord=%0d w=%0d", combo, first_o, w), s1, e1);
    check($sformatf("R5 second sum combo=%0d ord=%0d w=%0d", combo, first_o, w), s2, e2);
    check($sformatf("R4/R5 flags combo=%0d ord=%0d w=%0d", combo, first_o, w), 64'(f2), 64'(mflags));
    // R9 closed form: result = x + cin - 1, carry = cin | (x != 0)
    expc = ((w ? ac : {32'h0, ac[31:0]}) + 64'(ic) - 64'd1) & ones;
    expo = (ao + 64'(io) - 64'd1) & ones;
    check($sformatf("R9 carry-chain result combo=%0d ord=%0d w=%0d", combo, first_o, w),
          first_o ? s2 : s1, expc);
    check($sformatf("R9 overflow-chain result combo=%0d ord=%0d w=%0d", combo, first_o, w),
          first_o ? s1 : s2, expo);
    check($sformatf("R9 carry flag combo=%0d ord=%0d w=%0d", combo, first_o, w),
          64'(f2[CB]), 64'(ic | xc));
    check($sformatf("R9 overflow flag combo=%0d ord=%0d w=%0d", combo, first_o, w),
          64'(f2[OB]), 64'(io | xo));
    if (f1 === 16'hxxxx) check("R5 flags unknown", 64'(f1), 64'(0));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] s, e, a, b;
    logic [FW-1:0] f, fl;
    logic c;
    mflags = '0;
    #12;
    check("R1 reset flags", 64'(flags_q), 64'(0));
    check("R1 reset sum", sum_q, 64'(0));
    @(negedge clk);
    rst_n = 1'b1;

    // exhaustive 16 combinations, both orders, both widths
    for (int w = 0; w < 2; w++)
      for (int ord = 0; ord < 2; ord++)
        for (int k = 0; k < 16; k++)
          run_pair(ord[0], w[0], k);

    // random sweep of sums and carries, chains chosen at random
    load(16'h0000);
    for (int i = 0; i < 300; i++) begin
      lfsr = next_rand(lfsr); a = lfsr;
      lfsr = next_rand(lfsr); b = lfsr;
      lfsr = next_rand(lfsr);
      if (lfsr[7:0] == 8'h00) load(lfsr[23:8]);
      begin
        logic ch, w;
        ch = lfsr[30]; w = lfsr[31];
        model(ch, w, a, b, e, c);
        issue(ch, w, a, b, s, f);
        check($sformatf("%s random sum i=%0d w=%0d", ch ? "R3" : "R2", i, w), s, e);
        check($sformatf("R6/R4 random flags i=%0d", i), 64'(f), 64'(mflags));
      end
    end

    // R6: 32-bit mode drops upper bits and carries out of bit 32
    load(16'h0000);
    model(1'b0, 1'b0, 64'hffff_ffff_ffff_ffff, 64'h0000_0001_0000_0001, e, c);
    issue(1'b0, 1'b0, 64'hffff_ffff_ffff_ffff, 64'h0000_0001_0000_0001, s, f);
    check("R6 narrow sum", s, 64'h0000_0000_0000_0000);
    check("R6 narrow carry", 64'(f[CB]), 64'(1));

    // R7: load in same cycle as an op wins for flags; sum still written
    load(16'h0000);
    @(negedge clk);
    op_valid = 1'b1; op_chain = 1'b0; op_wide = 1'b1;
    opa = '1; opb = 64'h2;
    flag_ld = 1'b1; flag_ld_data = 16'h0800;
    @(posedge clk); #1;
    op_valid = 1'b0; flag_ld = 1'b0;
    check("R7 load overrides op flags", 64'(flags_q), 64'h0800);
    check("R7 op sum written", sum_q, 64'h1);
    mflags = 16'h0800;

    // R8: idle cycles hold everything
    fl = flags_q; s = sum_q;
    @(negedge clk); opa = 64'h77; opb = 64'h99; op_chain = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R8 idle flags", 64'(flags_q), 64'(fl));
    check("R8 idle sum", sum_q, s);

    // R4: all unrelated bits kept on both chains
    load(16'hf7fe);
    model(1'b0, 1'b1, '1, 64'h1, e, c);
    issue(1'b0, 1'b1, '1, 64'h1, s, f);
    check("R4 others kept after carry op", 64'(f), 64'(mflags));
    model(1'b1, 1'b1, '1, 64'h1, e, c);
    issue(1'b1, 1'b1, '1, 64'h1, s, f);
    check("R4 others kept after overflow op", 64'(f), 64'(mflags));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule